// File: doc/BRIEF.md
# Multi-Mode SPI Master Engine

This block is a SPI master driven by a stream of command words. Each command either drives a chip-select line or moves one byte over the link. A data command can also capture the byte that comes back. Commands enter through a valid/ready stream and wait in a 32-entry command queue. Captured bytes leave through a second valid/ready stream, backed by a 32-entry response queue.

A 2-bit mode value travels with each command and picks the link format for that byte:

| Mode | Format | Data pins | Bit rate | SPI clocks per byte |
|------|--------|-----------|----------|---------------------|
| 0 | full duplex: out on pin 0, in on pin 1 | 1 | SDR | 8 |
| 1 | half duplex | 4 | SDR | 2 |
| 2 | half duplex | 2 | SDR | 4 |
| 3 | half duplex | 4 | DDR | 1 |

SCLK idles low. Each SCLK level lasts (`clk_div` + 1) system clocks. Data is launched at transfer start and on falling edges, and sampled on rising edges; in DDR, data is both sampled and launched on every edge. Bits go out most significant first. Within a group of bits, the higher-order bit sits on the higher-numbered pin.

Back-pressure on the command stream: a word is taken on a cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low only while 32 words are waiting. On the response stream, a byte leaves on a cycle where `rsp_valid` and `rsp_ready` are both high. Holding `rsp_ready` low lets the response queue fill. Once it is full, the next capturing command waits at the head of the command queue, and every command behind it waits too.

Top module: `spi_xfer_engine`

## Requirements
- R1: While reset is held: `sclk` is 0, every `ss_n` bit is 1, `dq_oe` is 0, `cmd_ready` is 1 and `rsp_valid` is 0.
- R2: The command queue holds 32 words. `cmd_ready` is 0 exactly when 32 words are waiting, and each handshake stores {`cmd_mode`, `cmd_word`}.
- R3: A word with bit 8 = 1 is a select command. If its index (bits 3:0) is below SS_WIDTH, `ss_n[index]` becomes the inverse of bit 7 one cycle after the command leaves the queue. An index at or above SS_WIDTH changes nothing. `ss_n` never changes while a transfer runs.
- R4: During a transfer, `sclk` toggles once every (`clk_div`+1) clocks. It starts low and ends low, and it stays low between transfers.
- R5: Mode 0 runs 8 SCLK periods per byte. It sends bit 7 first on `dq_o[0]`, samples `dq_i[1]` on each rising edge, and drives `dq_oe` = 4'b0001.
- R6: Mode 1 runs 2 SCLK periods per byte. The high nibble goes out first on `dq_o[3:0]`, and bit 7 is on pin 3.
- R7: Mode 2 runs 4 SCLK periods per byte, on `dq_o[1:0]`, with the higher bit of each pair on pin 1.
- R8: Mode 3 runs 1 SCLK period per byte. It samples and shifts 4 bits on both edges.
- R9: In modes 1 to 3, `dq_oe` enables the used pins only for a write (bit 9 = 0). It is 0 for a capturing transfer and 0 when idle.
- R10: A data command pushes its captured byte into the response queue only when bit 9 = 1. Bytes come out on `rsp_byte` in order.
- R11: A capturing command does not start while 32 bytes are waiting in the response queue. No SCLK edge occurs until space frees.
- R12: The first bit group of a byte is on `dq_o` with `sclk` low from the first transfer cycle, before the first edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command word offered |
| cmd_ready | output | 1 | Command queue has room |
| cmd_word | input | 10 | bit9 capture, bit8 select cmd, bit7 select level, bits7:0 data byte, bits3:0 select index |
| cmd_mode | input | 2 | Link format for a data command |
| rsp_valid | output | 1 | Captured byte available |
| rsp_ready | input | 1 | Consumer takes the byte |
| rsp_byte | output | 8 | Captured byte |
| clk_div | input | 12 | SCLK half-period minus one, in clocks |
| sclk | output | 1 | SPI clock |
| ss_n | output | SS_WIDTH | Active-low chip selects |
| dq_o | output | 4 | Data pin output values |
| dq_oe | output | 4 | Data pin output enables |
| dq_i | input | 4 | Data pin input values |

## Verification
The bench builds the engine with two select lines, so a second line and an out-of-range index can both be exercised. The queue depths stay at the default of 32 and the divider at 12 bits. Divider values of 0 to 3 keep each byte short, so both queues can be filled within a few hundred cycles. That makes the full-queue back-pressure, the stall on a full response queue, and long mixed-mode bursts cheap to reach. Meanwhile a behavioural model tracks every pin on every cycle.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;
  localparam int DATA_W = 8;
  localparam int PINS   = 4;
  localparam int MODE_W = 2;
  localparam int WORD_W = 10;
  localparam int EDGE_W = $clog2(2 * DATA_W + 1);

  typedef struct packed {
    logic [2:0]        width;
    logic              ddr;
    logic              half;
    logic [EDGE_W-1:0] edges;
  } lane_cfg_t;

  function automatic lane_cfg_t mode_cfg(input logic [MODE_W-1:0] m);
    lane_cfg_t c;
    case (m)
      2'd0: begin c.width = 3'd1; c.half = 1'b0; c.ddr = 1'b0; c.edges = EDGE_W'(2 * DATA_W);     end
      2'd1: begin c.width = 3'd4; c.half = 1'b1; c.ddr = 1'b0; c.edges = EDGE_W'(2 * DATA_W / 4); end
      2'd2: begin c.width = 3'd2; c.half = 1'b1; c.ddr = 1'b0; c.edges = EDGE_W'(2 * DATA_W / 2); end
      default: begin c.width = 3'd4; c.half = 1'b1; c.ddr = 1'b1; c.edges = EDGE_W'(DATA_W / 4); end
    endcase
    return c;
  endfunction
endpackage

// File: rtl/spi_sfifo.sv
module spi_sfifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;
  logic             push, pop;

  assign in_ready  = (count != CW'(DEPTH));
  assign out_valid = (count != '0);
  assign out_data  = mem[rd_ptr];
  assign push      = in_valid && in_ready;
  assign pop       = out_valid && out_ready;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  // R2: occupancy never exceeds the queue depth
  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
endmodule

// File: rtl/spi_tick_gen.sv
module spi_tick_gen #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                 cnt <= cnt + DIV_W'(1);
  end
endmodule

// File: rtl/spi_lane_shifter.sv
module spi_lane_shifter
  import spi_xfer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] start_data,
  input  logic [MODE_W-1:0] start_mode,
  input  logic              start_read,
  input  logic              tick,
  input  logic [PINS-1:0]   dq_i,
  output logic              busy,
  output logic              cap_valid,
  output logic [DATA_W-1:0] cap_byte,
  output logic              sclk,
  output logic [PINS-1:0]   dq_o,
  output logic [PINS-1:0]   dq_oe
);
  logic              busy_q, sclk_q, read_q;
  logic [DATA_W-1:0] tx_q, rx_q, rx_next, tx_next;
  lane_cfg_t         cfg_q;
  logic [EDGE_W-1:0] edge_q;
  logic              rising, do_sample, do_shift, last_edge, step;
  logic              mosi_bit;

  assign rising    = !sclk_q;
  assign do_sample = cfg_q.ddr || rising;
  assign do_shift  = cfg_q.ddr || !rising;
  assign last_edge = (edge_q == cfg_q.edges - EDGE_W'(1));
  assign step      = busy_q && tick;
  assign mosi_bit  = cfg_q.half ? dq_i[0] : dq_i[1];
  assign tx_next   = tx_q << cfg_q.width;

  always_comb begin
    case (cfg_q.width)
      3'd1:    rx_next = {rx_q[DATA_W-2:0], mosi_bit};
      3'd2:    rx_next = {rx_q[DATA_W-3:0], dq_i[1:0]};
      default: rx_next = {rx_q[DATA_W-5:0], dq_i[3:0]};
    endcase
  end

  always_comb begin
    dq_o  = '0;
    dq_oe = '0;
    for (int i = 0; i < PINS; i++) begin
      if (busy_q && i < int'(cfg_q.width)) begin
        dq_o[i] = tx_q[DATA_W - int'(cfg_q.width) + i];
        if (cfg_q.half && !read_q) dq_oe[i] = 1'b1;
      end
    end
    if (busy_q && !cfg_q.half) dq_oe[0] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      read_q <= 1'b0;
      tx_q   <= '0;
      rx_q   <= '0;
      cfg_q  <= mode_cfg('0);
      edge_q <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      sclk_q <= 1'b0;
      read_q <= start_read;
      tx_q   <= start_data;
      rx_q   <= '0;
      cfg_q  <= mode_cfg(start_mode);
      edge_q <= '0;
    end else if (step) begin
      sclk_q <= !sclk_q;
      if (do_sample) rx_q <= rx_next;
      if (do_shift)  tx_q <= tx_next;
      edge_q <= edge_q + EDGE_W'(1);
      if (last_edge) busy_q <= 1'b0;
    end
  end

  assign busy      = busy_q;
  assign sclk      = sclk_q;
  assign cap_valid = step && last_edge && read_q;
  assign cap_byte  = do_sample ? rx_next : rx_q;

  // R4: clock rests low whenever no byte is moving
  assert_sclk_idle_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !sclk_q);
  // R4: clock level only moves on a prescaler tick
  assert_sclk_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !tick) |=> $stable(sclk_q));
  // R4: every transfer finishes with the clock low
  assert_end_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> !sclk_q);
endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
  import spi_xfer_pkg::*;
#(
  parameter int SS_WIDTH  = 1,
  parameter int DIV_W     = 12,
  parameter int CMD_DEPTH = 32,
  parameter int RSP_DEPTH = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic [WORD_W-1:0]   cmd_word,
  input  logic [MODE_W-1:0]   cmd_mode,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [DATA_W-1:0]   rsp_byte,
  input  logic [DIV_W-1:0]    clk_div,
  output logic                sclk,
  output logic [SS_WIDTH-1:0] ss_n,
  output logic [PINS-1:0]     dq_o,
  output logic [PINS-1:0]     dq_oe,
  input  logic [PINS-1:0]     dq_i
);
  localparam int QW = MODE_W + WORD_W;

  logic [QW-1:0]     head;
  logic              head_valid, head_take;
  logic              is_sel, is_cap, rsp_room;
  logic              busy, tick, start, sel_take;
  logic              cap_valid;
  logic [DATA_W-1:0] cap_byte;
  logic [SS_WIDTH-1:0] ss_q;

  spi_sfifo #(.WIDTH(QW), .DEPTH(CMD_DEPTH)) u_cmd_q (
    .clk(clk), .rst_n(rst_n),
    .in_valid(cmd_valid), .in_ready(cmd_ready), .in_data({cmd_mode, cmd_word}),
    .out_valid(head_valid), .out_ready(head_take), .out_data(head)
  );

  assign is_sel    = head[8];
  assign is_cap    = head[9];
  assign head_take = head_valid && !busy && (is_sel || !is_cap || rsp_room);
  assign start     = head_take && !is_sel;
  assign sel_take  = head_take && is_sel;

  spi_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(busy), .div(clk_div), .tick(tick)
  );

  spi_lane_shifter u_lane (
    .clk(clk), .rst_n(rst_n),
    .start(start), .start_data(head[DATA_W-1:0]),
    .start_mode(head[QW-1:WORD_W]), .start_read(is_cap),
    .tick(tick), .dq_i(dq_i),
    .busy(busy), .cap_valid(cap_valid), .cap_byte(cap_byte),
    .sclk(sclk), .dq_o(dq_o), .dq_oe(dq_oe)
  );

  spi_sfifo #(.WIDTH(DATA_W), .DEPTH(RSP_DEPTH)) u_rsp_q (
    .clk(clk), .rst_n(rst_n),
    .in_valid(cap_valid), .in_ready(rsp_room), .in_data(cap_byte),
    .out_valid(rsp_valid), .out_ready(rsp_ready), .out_data(rsp_byte)
  );

  for (genvar g = 0; g < SS_WIDTH; g++) begin : g_sel
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            ss_q[g] <= 1'b1;
      else if (sel_take && head[3:0] == 4'(g)) ss_q[g] <= !head[7];
    end
  end

  assign ss_n = ss_q;

  // R11: a finished capture always finds a free response slot
  assert_rsp_room_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid |-> rsp_room);
  // R3: select lines hold still across a running transfer
  assert_ss_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(ss_n));
endmodule

// File: tb/test_spi_xfer_engine.sv
`timescale 1ns/1ps
module test_spi_xfer_engine;
  localparam int SSW = 2;
  localparam int DEPTH = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       cmd_valid = 1'b0;
  logic [9:0] cmd_word = '0;
  logic [1:0] cmd_mode = '0;
  logic       rsp_ready;
  logic [11:0] clk_div = '0;
  logic [3:0] dq_i;
  wire        cmd_ready, rsp_valid, sclk;
  wire [7:0]  rsp_byte;
  wire [SSW-1:0] ss_n;
  wire [3:0]  dq_o, dq_oe;

  spi_xfer_engine #(.SS_WIDTH(SSW)) i_spi_xfer_engine (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_word(cmd_word), .cmd_mode(cmd_mode), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_byte(rsp_byte), .clk_div(clk_div),
    .sclk(sclk), .ss_n(ss_n), .dq_o(dq_o), .dq_oe(dq_oe), .dq_i(dq_i)
  );

  // stimulus flags, written only by the main sequence
  bit rsp_rand = 0, rsp_hold = 0, lfsr_on = 1, run_cmp = 0;
  logic [3:0] dq_fixed = '0;
  logic [15:0] lfsr = 16'hACE1;

  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    dq_i <= lfsr_on ? lfsr[3:0] : dq_fixed;
    rsp_ready <= rsp_rand ? lfsr[5] : rsp_hold;
  end

  // behavioural reference model
  logic [11:0] q_cmd[$];
  logic [7:0]  q_rsp[$];
  bit m_busy, m_sclk, m_read;
  int m_cnt, m_edge, m_mode;
  logic [7:0] m_tx, m_rx;
  logic [SSW-1:0] m_ss;

  function automatic int lanes(input int md);
    return (md == 0) ? 1 : (md == 2) ? 2 : 4;
  endfunction

  always @(posedge clk) begin
    bit cacc, racc, ppush, cpop, d, rising;
    logic [7:0] pval, grp;
    logic [11:0] c;
    int w, e;
    if (!rst_n) begin
      q_cmd.delete(); q_rsp.delete();
      m_busy = 0; m_sclk = 0; m_read = 0; m_cnt = 0; m_edge = 0; m_mode = 0;
      m_tx = 0; m_rx = 0; m_ss = '1;
    end else begin
      cacc = cmd_valid && (q_cmd.size() < DEPTH);
      racc = rsp_ready && (q_rsp.size() > 0);
      ppush = 0; cpop = 0; pval = 0;
      if (!m_busy) begin
        if (q_cmd.size() > 0) begin
          c = q_cmd[0];
          if (c[8]) begin
            cpop = 1;
            if (int'(c[3:0]) < SSW) m_ss[int'(c[3:0])] = ~c[7];
          end else if (!(c[9] && q_rsp.size() >= DEPTH)) begin
            cpop = 1; m_busy = 1; m_cnt = 0; m_edge = 0;
            m_tx = c[7:0]; m_rx = 0; m_mode = int'(c[11:10]); m_read = c[9];
          end
        end
      end else if (m_cnt == int'(clk_div)) begin
        w = lanes(m_mode);
        d = (m_mode == 3);
        e = d ? 8 / w : 16 / w;
        rising = !m_sclk;
        grp = (w == 1) ? {7'b0, dq_i[1]} : (w == 2) ? {6'b0, dq_i[1:0]} : {4'b0, dq_i};
        if (d || rising) m_rx = 8'((m_rx << w) | grp);
        if (d || !rising) m_tx = 8'(m_tx << w);
        m_sclk = !m_sclk;
        m_cnt = 0;
        if (m_edge == e - 1) begin
          m_busy = 0;
          if (m_read) begin ppush = 1; pval = m_rx; end
        end else m_edge++;
      end else m_cnt++;
      if (racc) void'(q_rsp.pop_front());
      if (ppush) q_rsp.push_back(pval);
      if (cpop) void'(q_cmd.pop_front());
      if (cacc) q_cmd.push_back({cmd_mode, cmd_word});
    end
  end

  // per-clock comparison
  int mon_checks = 0, mon_fails = 0, rise_cnt = 0, oe_cnt = 0;
  bit prev_sclk = 0;

  task automatic mcmp(input string req, input string what, input int act, input int exp);
    mon_checks++;
    if (act != exp) begin
      mon_fails++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    logic [3:0] e_o, e_oe;
    int w;
    if (rst_n && run_cmp) begin
      e_o = '0; e_oe = '0;
      if (m_busy) begin
        w = lanes(m_mode);
        for (int i = 0; i < w; i++) e_o[i] = m_tx[8 - w + i];
        if (m_mode == 0) e_oe = 4'b0001;
        else if (!m_read) e_oe = (w == 2) ? 4'b0011 : 4'b1111;
      end
      mcmp("R4", "sclk", int'(sclk), int'(m_sclk));
      mcmp("R3", "ss_n", int'(ss_n), int'(m_ss));
      mcmp("R5", "dq_o", int'(dq_o), int'(e_o));
      mcmp("R9", "dq_oe", int'(dq_oe), int'(e_oe));
      mcmp("R2", "cmd_ready", int'(cmd_ready), int'(q_cmd.size() < DEPTH));
      mcmp("R10", "rsp_valid", int'(rsp_valid), int'(q_rsp.size() > 0));
      if (q_rsp.size() > 0) mcmp("R10", "rsp_byte", int'(rsp_byte), int'(q_rsp[0]));
      if (sclk && !prev_sclk) rise_cnt++;
      if (dq_oe != 0) oe_cnt++;
    end
    prev_sclk = sclk;
  end

  // directed sequence
  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] md, input logic [9:0] w);
    @(negedge clk);
    cmd_mode = md; cmd_word = w; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  function automatic logic [9:0] dcmd(input bit rd, input logic [7:0] b);
    return {rd, 1'b0, b};
  endfunction

  function automatic logic [9:0] scmd(input bit lvl, input logic [3:0] idx);
    return {1'b0, 1'b1, lvl, 3'b0, idx};
  endfunction

  task automatic wait_idle();
    int n = 0;
    @(negedge clk);
    while ((q_cmd.size() != 0 || m_busy) && n < 5000) begin
      @(negedge clk); n++;
    end
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks + mon_checks, fails + mon_fails);
  endtask

  int base_r, base_o;

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(sclk == 1'b0, "R1", "sclk", int'(sclk), 0);
    chk(ss_n == '1, "R1", "ss_n", int'(ss_n), 3);
    chk(dq_oe == 4'b0, "R1", "dq_oe", int'(dq_oe), 0);
    chk(cmd_ready == 1'b1, "R1", "cmd_ready", int'(cmd_ready), 1);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid", int'(rsp_valid), 0);
    rst_n = 1'b1; run_cmp = 1; rsp_hold = 1;
    @(negedge clk);

    // R5 / R4: full duplex byte, 8 rising edges, 16*(div+1) busy cycles
    clk_div = 12'd2;
    base_r = rise_cnt; base_o = oe_cnt;
    push(2'd0, dcmd(1'b0, 8'hA5));
    wait_idle();
    chk(rise_cnt - base_r == 8, "R5", "mode0 rising edges", rise_cnt - base_r, 8);
    chk(oe_cnt - base_o == 48, "R4", "mode0 busy cycles", oe_cnt - base_o, 48);

    // R5: capture from pin 1 with fixed input
    lfsr_on = 0; dq_fixed = 4'b1010; rsp_hold = 0; clk_div = 12'd0;
    push(2'd0, dcmd(1'b1, 8'h3C));
    wait_idle();
    chk(rsp_valid && rsp_byte == 8'hFF, "R5", "mode0 capture", int'(rsp_byte), 8'hFF);
    rsp_hold = 1; repeat (3) @(negedge clk);

    // R6: quad capture, nibble order
    rsp_hold = 0;
    base_r = rise_cnt;
    push(2'd1, dcmd(1'b1, 8'h00));
    wait_idle();
    chk(rsp_valid && rsp_byte == 8'hAA, "R6", "mode1 capture", int'(rsp_byte), 8'hAA);
    chk(rise_cnt - base_r == 2, "R6", "mode1 rising edges", rise_cnt - base_r, 2);
    rsp_hold = 1; repeat (3) @(negedge clk);

    // R8: quad DDR capture on both edges
    rsp_hold = 0; dq_fixed = 4'b0110; clk_div = 12'd1;
    base_r = rise_cnt;
    push(2'd3, dcmd(1'b1, 8'h00));
    wait_idle();
    chk(rsp_valid && rsp_byte == 8'h66, "R8", "mode3 capture", int'(rsp_byte), 8'h66);
    chk(rise_cnt - base_r == 1, "R8", "mode3 rising edges", rise_cnt - base_r, 1);
    rsp_hold = 1; repeat (3) @(negedge clk);
    lfsr_on = 1;

    // R10: write-only command pushes nothing
    rsp_hold = 0;
    push(2'd0, dcmd(1'b0, 8'h5A));
    wait_idle();
    chk(!rsp_valid, "R10", "no byte after write", int'(rsp_valid), 0);
    rsp_hold = 1;

    // R3: select commands
    push(2'd0, scmd(1'b1, 4'd0));
    wait_idle();
    chk(ss_n == 2'b10, "R3", "assert line 0", int'(ss_n), 2);
    push(2'd0, scmd(1'b1, 4'd1));
    wait_idle();
    chk(ss_n == 2'b00, "R3", "assert line 1", int'(ss_n), 0);
    push(2'd0, scmd(1'b0, 4'd5));
    wait_idle();
    chk(ss_n == 2'b00, "R3", "index beyond lines ignored", int'(ss_n), 0);
    push(2'd0, scmd(1'b0, 4'd0));
    wait_idle();
    chk(ss_n == 2'b01, "R3", "release line 0", int'(ss_n), 1);

    // R12 / R9: first nibble launched before first edge, pins driven for write
    clk_div = 12'd3;
    push(2'd1, dcmd(1'b0, 8'hC3));
    begin
      int n = 0;
      while (dq_oe == 4'b0 && n < 50) begin @(negedge clk); n++; end
    end
    chk(dq_o == 4'hC && sclk == 1'b0, "R12", "first group before edge", int'({sclk, dq_o}), 8'h0C);
    chk(dq_oe == 4'hF, "R9", "quad write enables", int'(dq_oe), 4'hF);
    wait_idle();

    // R7: dual write edges; dual capture keeps pins released (R9)
    clk_div = 12'd0;
    base_r = rise_cnt;
    push(2'd2, dcmd(1'b0, 8'h96));
    wait_idle();
    chk(rise_cnt - base_r == 4, "R7", "mode2 rising edges", rise_cnt - base_r, 4);
    base_o = oe_cnt;
    push(2'd2, dcmd(1'b1, 8'h96));
    wait_idle();
    chk(oe_cnt == base_o, "R9", "capture leaves pins released", oe_cnt - base_o, 0);

    // mixed burst with random back-pressure
    rsp_rand = 1;
    for (int k = 0; k < 40; k++) begin
      if (k % 10 == 9) push(2'd0, scmd(k[0], 4'(k % 3)));
      else push(2'(k % 4), dcmd(k % 3 == 0, 8'(k * 37 + 5)));
    end
    wait_idle();
    rsp_rand = 0; rsp_hold = 1;
    repeat (40) @(negedge clk);
    chk(!rsp_valid, "R10", "burst drained", int'(rsp_valid), 0);

    // R11 / R2: fill response queue, then stall and fill command queue
    rsp_hold = 0;
    for (int k = 0; k < DEPTH; k++) push(2'd3, dcmd(1'b1, 8'(k)));
    wait_idle();
    base_r = rise_cnt;
    push(2'd3, dcmd(1'b1, 8'h11));
    repeat (60) @(negedge clk);
    chk(rise_cnt == base_r, "R11", "no edge while response full", rise_cnt - base_r, 0);
    for (int k = 0; k < DEPTH - 1; k++) push(2'd0, dcmd(1'b0, 8'(k)));
    chk(cmd_ready == 1'b0, "R2", "ready low at 32 words", int'(cmd_ready), 0);
    rsp_hold = 1;
    wait_idle();
    repeat (40) @(negedge clk);
    chk(cmd_ready && !rsp_valid, "R2", "queues drained", int'({cmd_ready, rsp_valid}), 2);

    finished = 1;
    summary();
    $finish;
  end

  int cyc = 0;
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
      $display("  TB_RESULT checks=%0d failures=%0d", checks + mon_checks + 1, fails + mon_fails + 1);
      $finish;
    end
  end
endmodule